// File: doc/BRIEF.md
# Dual-Bus Microcoded Core with Bus Bridge

This block is a small processor core with two separate 32-bit buses, one for data and one for addresses. Two directional gates join them: one copies the data bus onto the address bus, the other copies the address-side source onto the data bus. Each gate has its own control bit. The datapath holds a program counter that increments itself, an instruction register, an accumulator, a two-bit flag register and a register file with two read ports and one write port. An ALU with eight operations sits in the datapath: add, multiply, arithmetic shift left, arithmetic shift right, AND, OR, XOR and logical shift right. Its 3-bit operation select comes from the microinstruction.

A microprogram sequencer drives every control bit. Its address space spans 64K words, and the words are computed by a function rather than stored. Every instruction is four words long. Fetch reads all four words. Only one instruction is executed: the destination register is XORed with the memory word at base register plus displacement, and the result goes back to the destination register. The ALU forms the effective address and the accumulator holds it. The address then crosses to the address bus through the data-to-address gate and is latched there, so it stays on the address bus for the operand read.

The testbench supplies memory, which answers a read in the same cycle. For observation, the core exposes the register write port and the flags.

Top module: `dual_bus_core`

## Requirements
- R1: While reset is low, the address bus shows RESET_PC with read asserted, the flags are 0 and no register write is signalled.
- R2: An instruction starts at word address P. In its cycles 0 to 3 the core reads words P, P+1, P+2 and P+3. The program counter advances by one per word without using the ALU.
- R3: In the first instruction word, bits [31:24] hold the opcode, bits [23:20] the destination index and bits [19:16] the base index. The second word is the displacement. The third and fourth words are read and ignored.
- R4: In cycle 5 of an XOR instruction, the address bus carries the effective address with read asserted. The effective address is base register plus displacement, modulo 2^32.
- R5: In cycle 6 of an XOR instruction, wb_valid_o is high and the destination register receives its old value XOR the memory word at the effective address. The next instruction starts in cycle 7.
- R6: flags_o bit 0 is set when the XOR result is zero, and bit 1 is set when its bit 31 is one. The flags are updated only by an XOR instruction.
- R7: An instruction whose opcode is not XOR_OPC writes no register and leaves the flags unchanged. The next instruction starts 4 cycles after it began.
- R8: After reset, register i holds REG_SEED*(i+1), modulo 2^32.
- R9: When the destination equals the base, the effective address uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | DATA_W | Address bus, word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | DATA_W | Read data, returned in the same cycle |
| wb_valid_o | output | 1 | Register write this cycle |
| wb_idx_o | output | $clog2(NREGS) | Index of the register being written |
| wb_data_o | output | DATA_W | Data being written to the register |
| flags_o | output | 2 | Bit 0 zero, bit 1 negative |

## Verification
The bench builds the core with DATA_W=32, NREGS=16, REG_SEED=32'h0101_0101, XOR_OPC=8'h5C and RESET_PC=0. Because the seed is nonzero, every register starts with a distinct large value, so the first XOR already depends on the reset contents. With 32-bit data, a negative displacement wraps the effective address around zero. The 4-bit index field lets one instruction name the same register as both base and destination. Data words placed in the program region make the zero and negative flag cases occur by design rather than by chance.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int USTORE_DEPTH = 65536;
  localparam int UADDR_W      = $clog2(USTORE_DEPTH);

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_MUL = 3'd1, ALU_ASL = 3'd2, ALU_ASR = 3'd3,
    ALU_AND = 3'd4, ALU_OR  = 3'd5, ALU_XOR = 3'd6, ALU_LSR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic    rd;      // memory read onto data bus
    logic    inc;     // pc + 1
    logic    li;      // load instruction fields
    logic    tpc;     // pc onto address side
    logic    tdb2ab;  // data bus -> address bus gate
    logic    tab2db;  // address side -> data bus gate
    logic    ldab;    // latch address bus
    logic    tac;     // accumulator onto data bus
    logic    lac;     // load accumulator from alu
    logic    lr;      // register write from data bus
    logic    lflags;
    logic    xsel;    // 1: port a (dest), 0: port b (base)
    alu_op_e op;
  } ctrl_t;

  typedef struct packed {
    logic [UADDR_W-1:0] next;
    logic               dispatch;
    ctrl_t              ctl;
  } uinstr_t;

  function automatic uinstr_t ucode(input logic [UADDR_W-1:0] a);
    uinstr_t u;
    u = '0;
    u.ctl.op = ALU_ADD;
    case (a)
      UADDR_W'(0): begin
        u.ctl.tpc = 1'b1; u.ctl.rd = 1'b1; u.ctl.inc = 1'b1; u.ctl.li = 1'b1;
        u.next = UADDR_W'(1);
      end
      UADDR_W'(1): begin  // displacement + base -> acc
        u.ctl.tpc = 1'b1; u.ctl.rd = 1'b1; u.ctl.inc = 1'b1;
        u.ctl.lac = 1'b1; u.ctl.xsel = 1'b0; u.ctl.op = ALU_ADD;
        u.next = UADDR_W'(2);
      end
      UADDR_W'(2): begin
        u.ctl.tpc = 1'b1; u.ctl.rd = 1'b1; u.ctl.inc = 1'b1;
        u.next = UADDR_W'(3);
      end
      UADDR_W'(3): begin
        u.ctl.tpc = 1'b1; u.ctl.rd = 1'b1; u.ctl.inc = 1'b1;
        u.dispatch = 1'b1; u.next = UADDR_W'(4);
      end
      UADDR_W'(4): begin  // acc across the bridge into the address latch
        u.ctl.tac = 1'b1; u.ctl.tdb2ab = 1'b1; u.ctl.ldab = 1'b1;
        u.next = UADDR_W'(5);
      end
      UADDR_W'(5): begin
        u.ctl.rd = 1'b1; u.ctl.xsel = 1'b1; u.ctl.op = ALU_XOR;
        u.ctl.lac = 1'b1; u.ctl.lflags = 1'b1;
        u.next = UADDR_W'(6);
      end
      UADDR_W'(6): begin
        u.ctl.tac = 1'b1; u.ctl.lr = 1'b1;
        u.next = UADDR_W'(0);
      end
      default: u.next = UADDR_W'(0);
    endcase
    return u;
  endfunction
endpackage

// File: rtl/dbc_alu.sv
module dbc_alu import dbc_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] r_o
);
  localparam int SH_W = $clog2(DATA_W);
  logic [SH_W-1:0] sh;
  assign sh = y_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      ALU_ADD: r_o = x_i + y_i;
      ALU_MUL: r_o = x_i * y_i;
      ALU_ASL: r_o = x_i << sh;
      ALU_ASR: r_o = $signed(x_i) >>> sh;
      ALU_AND: r_o = x_i & y_i;
      ALU_OR:  r_o = x_i | y_i;
      ALU_XOR: r_o = x_i ^ y_i;
      ALU_LSR: r_o = x_i >> sh;
      default: r_o = '0;
    endcase
  end
endmodule

// File: rtl/dbc_regfile.sv
module dbc_regfile #(
  parameter int              DATA_W   = 32,
  parameter int              NREGS    = 16,
  parameter logic [DATA_W-1:0] REG_SEED = '0,
  localparam int             IDX_W    = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_a_i,
  input  logic [IDX_W-1:0]  ra_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= DATA_W'(REG_SEED * (g + 1));
      else if (we_i && wa_i == IDX_W'(g))        regs_q[g] <= wd_i;
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];
endmodule

// File: rtl/dbc_useq.sv
module dbc_useq import dbc_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  opc_hit_i,
  output ctrl_t ctl_o
);
  logic [UADDR_W-1:0] upc_q, upc_d;
  uinstr_t            uw;

  assign uw    = ucode(upc_q);
  assign ctl_o = uw.ctl;
  assign upc_d = (uw.dispatch && !opc_hit_i) ? '0 : uw.next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  // a register write is always preceded by the operand read
  assert_wb_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.lr |-> $past(ctl_o.rd) && $past(ctl_o.lflags));
endmodule

// File: rtl/dual_bus_core.sv
module dual_bus_core import dbc_pkg::*; #(
  parameter int                DATA_W   = 32,
  parameter int                NREGS    = 16,
  parameter logic [DATA_W-1:0] REG_SEED = 32'h0101_0101,
  parameter logic [7:0]        XOR_OPC  = 8'h5C,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  output logic [DATA_W-1:0]        mem_addr_o,
  output logic                     mem_rd_o,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic                     wb_valid_o,
  output logic [$clog2(NREGS)-1:0] wb_idx_o,
  output logic [DATA_W-1:0]        wb_data_o,
  output logic [1:0]               flags_o
);
  localparam int IDX_W  = $clog2(NREGS);
  localparam int OPC_LO = DATA_W - 8;
  localparam int IA_LO  = OPC_LO - IDX_W;
  localparam int IB_LO  = IA_LO - IDX_W;

  ctrl_t             ctl;
  logic [DATA_W-1:0] pc_q, acc_q, addr_q;
  logic [7:0]        opc_q;
  logic [IDX_W-1:0]  ia_q, ib_q;
  logic [1:0]        flags_q;
  logic [DATA_W-1:0] dbus, abus, ab_src, alu_x, alu_r, rd_a, rd_b;

  dbc_useq u_useq (
    .clk_i, .rst_ni,
    .opc_hit_i (opc_q == XOR_OPC),
    .ctl_o     (ctl)
  );

  dbc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .REG_SEED(REG_SEED)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i (ia_q), .ra_b_i (ib_q),
    .rd_a_o (rd_a), .rd_b_o (rd_b),
    .we_i   (ctl.lr), .wa_i (ia_q), .wd_i (dbus)
  );

  dbc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (ctl.op), .x_i (alu_x), .y_i (dbus), .r_o (alu_r)
  );

  assign alu_x  = ctl.xsel ? rd_a : rd_b;
  // address-side source; the bridge to the data bus takes it from here
  assign ab_src = ctl.tpc ? pc_q : addr_q;
  assign abus   = ctl.tdb2ab ? dbus : ab_src;

  always_comb begin
    if (ctl.rd)          dbus = mem_rdata_i;
    else if (ctl.tac)    dbus = acc_q;
    else if (ctl.tab2db) dbus = ab_src;
    else                 dbus = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      acc_q   <= '0;
      addr_q  <= '0;
      opc_q   <= '0;
      ia_q    <= '0;
      ib_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ctl.inc)    pc_q   <= pc_q + DATA_W'(1);
      if (ctl.lac)    acc_q  <= alu_r;
      if (ctl.ldab)   addr_q <= abus;
      if (ctl.li) begin
        opc_q <= dbus[DATA_W-1 -: 8];
        ia_q  <= dbus[IA_LO +: IDX_W];
        ib_q  <= dbus[IB_LO +: IDX_W];
      end
      if (ctl.lflags) flags_q <= {alu_r[DATA_W-1], alu_r == '0};
    end
  end

  assign mem_addr_o = abus;
  assign mem_rd_o   = ctl.rd;
  assign wb_valid_o = ctl.lr;
  assign wb_idx_o   = ia_q;
  assign wb_data_o  = dbus;
  assign flags_o    = flags_q;

  assert_dbus_one_driver_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl.rd, ctl.tac, ctl.tab2db}));
  assert_abus_one_driver_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl.tpc && ctl.tdb2ab) && !(ctl.tab2db && ctl.tdb2ab));
  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.inc |=> pc_q == $past(pc_q) + DATA_W'(1));
  assert_flags_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.lflags |=> flags_o == $past(flags_o));
  assert_read_on_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl.li |-> ctl.rd && mem_addr_o == pc_q);
endmodule

// File: tb/dual_bus_core_tb_top.sv
module dual_bus_core_tb_top;
  localparam int          W     = 32;
  localparam int          NR    = 16;
  localparam int          PROGW = 64;
  localparam logic [W-1:0] SEED = 32'h0101_0101;
  localparam logic [7:0]  OPC   = 8'h5C;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] mem_addr, rdata, wb_data;
  logic         mem_rd, wb_valid;
  logic [3:0]   wb_idx;
  logic [1:0]   flags;

  logic [W-1:0] prog [PROGW];

  function automatic logic [W-1:0] mem_word(input logic [W-1:0] a);
    if (a < W'(PROGW)) return prog[a[5:0]];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always_comb rdata = mem_word(mem_addr);

  dual_bus_core #(.DATA_W(W), .NREGS(NR), .REG_SEED(SEED), .XOR_OPC(OPC), .RESET_PC('0)) dut_i (
    .clk_i (clk), .rst_ni, .mem_addr_o (mem_addr), .mem_rd_o (mem_rd),
    .mem_rdata_i (rdata), .wb_valid_o (wb_valid), .wb_idx_o (wb_idx),
    .wb_data_o (wb_data), .flags_o (flags)
  );

  typedef struct { int cyc; logic [3:0] idx; logic [W-1:0] data; logic [1:0] fl; logic [W-1:0] ea; } wb_exp_t;
  typedef struct { int cyc; logic [W-1:0] addr; } f_exp_t;
  wb_exp_t wq[$];
  f_exp_t  fq[$];

  int nchk = 0, nbad = 0, cyc = 0, t = 0, pcw = 0;
  bit running = 1'b0, done = 1'b0;
  logic [W-1:0] m_reg [NR];
  logic [1:0]   m_fl = '0;
  logic [W-1:0] prev_addr = '0;
  logic         prev_rd = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  task automatic push_fetch();
    for (int j = 0; j < 4; j++) begin
      f_exp_t f;
      f.cyc = t + j; f.addr = W'(pcw + j);
      fq.push_back(f);
    end
  endtask

  // driver: lays down the instruction and queues the expected results
  task automatic add_xor(input logic [3:0] d, input logic [3:0] b, input logic [W-1:0] disp);
    wb_exp_t e;
    logic [W-1:0] res;
    prog[pcw]     = {OPC, d, b, 16'hBEEF};
    prog[pcw + 1] = disp;
    prog[pcw + 2] = {OPC, 24'hFFFFFF};
    prog[pcw + 3] = 32'hDEAD_0000 | W'(pcw);
    push_fetch();
    e.ea   = m_reg[b] + disp;
    res    = m_reg[d] ^ mem_word(e.ea);
    m_reg[d] = res;
    m_fl   = {res[W-1], res == '0};
    e.cyc  = t + 6; e.idx = d; e.data = res; e.fl = m_fl;
    wq.push_back(e);
    t   += 7;
    pcw += 4;
  endtask

  task automatic add_other(input logic [7:0] opc);
    prog[pcw]     = {opc, 4'hF, 4'hE, 16'h1234};
    prog[pcw + 1] = 32'h0000_1234;
    prog[pcw + 2] = '0;
    prog[pcw + 3] = '0;
    push_fetch();
    t   += 4;
    pcw += 4;
  endtask

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running && !done) begin
      if (fq.size() > 0 && fq[0].cyc == cyc) begin
        f_exp_t f;
        f = fq.pop_front();
        chk(mem_rd && mem_addr == f.addr, "R2", "fetch address", mem_addr, f.addr);
      end
      if (wb_valid) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R7", "unexpected register write", wb_data, '0);
        end else begin
          wb_exp_t e;
          e = wq.pop_front();
          chk(cyc == e.cyc, "R5", "write cycle", W'(cyc), W'(e.cyc));
          chk(wb_idx == e.idx, "R3", "write index", W'(wb_idx), W'(e.idx));
          chk(wb_data == e.data, "R5 R8 R9", "write data", wb_data, e.data);
          chk(flags == e.fl, "R6", "flags", W'(flags), W'(e.fl));
          chk(prev_rd && prev_addr == e.ea, "R4", "effective address", prev_addr, e.ea);
        end
      end
      prev_addr = mem_addr;
      prev_rd   = mem_rd;
    end
  end

  initial begin
    for (int i = 0; i < PROGW; i++) prog[i] = '0;
    for (int i = 0; i < NR; i++) m_reg[i] = W'(SEED * (i + 1));

    add_xor(4'hF, 4'hE, 32'h0000_1234);              // R8 reset contents
    add_xor(4'hF, 4'hE, 32'h0000_1234);              // chained
    add_other(8'h00);                                // R7
    add_xor(4'h3, 4'h3, 32'h0000_0010);              // R9 dest == base
    add_xor(4'h0, 4'hF, 32'hFFFF_FFF0);              // R4 wrap
    prog[60] = m_reg[7];
    add_xor(4'h7, 4'h2, W'(60) - m_reg[2]);          // R6 zero
    add_other(OPC ^ 8'h01);                          // R7
    prog[61] = m_reg[5] ^ 32'h8000_0000;
    add_xor(4'h5, 4'h9, W'(61) - m_reg[9]);          // R6 negative

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr == '0, "R1", "reset address", mem_addr, '0);
    chk(mem_rd == 1'b1, "R1", "reset read", W'(mem_rd), 1);
    chk(flags == 2'b00, "R1", "reset flags", W'(flags), 0);
    chk(wb_valid == 1'b0, "R1", "reset write", W'(wb_valid), 0);
    rst_ni  = 1'b1;
    running = 1'b1;

    while (cyc < t + 8) @(negedge clk);
    chk(wq.size() == 0, "R5", "writes missing", W'(wq.size()), 0);
    chk(fq.size() == 0, "R2", "fetches missing", W'(fq.size()), 0);
    chk(flags == m_fl, "R7", "final flags", W'(flags), W'(m_fl));
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", W'(cyc), W'(t));
    finish_run();
  end
endmodule